// File: doc/BRIEF.md
# Banked Memory Select and Write Guard

This block sits between a 16-bit processor's memory bus and a battery-backed word-wide RAM. It splits the 64K-byte address space into sixteen 4K-byte banks, using the top four address bits as the bank number. Each bank has an access switch and a separate write-permit switch. From these inputs the block produces the RAM chip enable, write enable and output enable. It also produces the enable and direction for the data-bus transceiver. A power-fail input withholds chip enable so that the RAM contents stay intact while the supply is out of tolerance.

The decoded bank is also brought out as a sixteen-bit one-hot activity vector that can drive a bar-graph monitor. By default every output is registered, so the outputs reflect the bus inputs sampled at the previous rising clock edge. Setting `OUT_REG` to 0 makes the outputs follow the inputs in the same cycle. All outputs are active high, and the high and low data bytes are always accessed together.

Top module: `bank_mem_guard`

## Requirements
- R1: `bank_act` is all zero when `mem_en` is low. Otherwise exactly bit `addr_hi` is set, where `addr_hi` bit 3 is the most significant address bit.
- R2: `ram_ce` is high only when `mem_en` is high, bit `addr_hi` of `bank_on` is 1 and `pwr_fail` is low.
- R3: `ram_we` is high only when `wr_cyc` is high, `dbin` is low, and bit `addr_hi` of both `bank_on` and `bank_wr_ok` is 1, with `mem_en` high and `pwr_fail` low. A read, or a write to a bank whose `bank_wr_ok` bit is 0, leaves it low.
- R4: `xcvr_en` is high exactly when `mem_en` is high and bit `addr_hi` of `bank_on` is 1. `pwr_fail` has no effect on it.
- R5: `xcvr_to_cpu` equals `dbin`. A value of 1 drives data off the board toward the processor, and 0 drives data onto the board.
- R6: `ram_oe` equals `dbin`, so the RAM drives data only on read cycles.
- R7: While `pwr_fail` is high, `ram_ce` and `ram_we` are low for every bank and every cycle type.
- R8: A bank whose `bank_on` bit is 0 produces no `ram_ce`, `ram_we` or `xcvr_en`, whatever its `bank_wr_ok` bit is. Its `bank_act` bit is still set.
- R9: With `OUT_REG`=1, every output reflects the inputs sampled at the previous rising edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hi | input | 4 | Top four address bits (bit 3 = most significant) |
| mem_en | input | 1 | Memory cycle strobe, active high |
| dbin | input | 1 | High during read cycles |
| wr_cyc | input | 1 | High during write cycles |
| bank_on | input | 16 | Per-bank access switch, indexed by bank number |
| bank_wr_ok | input | 16 | Per-bank write-permit switch, indexed by bank number |
| pwr_fail | input | 1 | Supply out of tolerance, active high |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write enable |
| ram_oe | output | 1 | RAM output enable |
| xcvr_en | output | 1 | Data transceiver enable |
| xcvr_to_cpu | output | 1 | Transceiver direction, 1 = toward the processor |
| bank_act | output | 16 | One-hot decoded bank activity |

## Verification
The hardest case to reach is a write to a bank that is switched on but write-protected, with neighbouring banks left writable. A decoder that selects the wrong bank then reads the wrong permit bit and still raises the write enable. The bench walks all sixteen banks with checkerboard and single-bit switch patterns in both polarities. A fault in the bank index therefore changes the write enable for at least one bank. Power failure is raised in the middle of write cycles to enabled, writable banks. This separates the chip-enable gating, which power failure blocks, from the transceiver enable, which it does not.

// File: rtl/bank_mem_pkg.sv
`timescale 1ns/1ps
package bank_mem_pkg;
   typedef struct packed {
      logic ce;
      logic we;
      logic oe;
      logic xen;
      logic xdir;
   } bank_ctl_t;
   localparam int CTL_W = $bits(bank_ctl_t);
endpackage

// File: rtl/bank_decoder.sv
`timescale 1ns/1ps
module bank_decoder #(
   parameter int SEL_W = 4,
   localparam int NUM_BANK = 1 << SEL_W
) (
   input  logic [SEL_W-1:0]    sel,
   input  logic                strobe,
   output logic [NUM_BANK-1:0] onehot
);
   for (genvar b = 0; b < NUM_BANK; b++) begin : g_line
      assign onehot[b] = strobe && (sel == SEL_W'(b));
   end
endmodule

// File: rtl/bank_gate.sv
`timescale 1ns/1ps
module bank_gate #(
   parameter int NUM_BANK = 16
) (
   input  logic [NUM_BANK-1:0] onehot,
   input  logic [NUM_BANK-1:0] bank_on,
   input  logic [NUM_BANK-1:0] bank_wr_ok,
   input  logic                wr_cyc,
   input  logic                dbin,
   input  logic                pwr_fail,
   output bank_mem_pkg::bank_ctl_t ctl
);
   logic [NUM_BANK-1:0] sel_hit;
   logic [NUM_BANK-1:0] wr_hit;
   logic                any_sel;
   logic                any_wr;

   for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
      assign sel_hit[b] = onehot[b] & bank_on[b];
      assign wr_hit[b]  = sel_hit[b] & bank_wr_ok[b];
   end

   assign any_sel = |sel_hit;
   assign any_wr  = |wr_hit;

   always_comb begin
      ctl.xen  = any_sel;
      ctl.ce   = any_sel & ~pwr_fail;
      ctl.we   = any_wr & wr_cyc & ~dbin & ~pwr_fail;
      ctl.oe   = dbin;
      ctl.xdir = dbin;
   end
endmodule

// File: rtl/bank_outstage.sv
`timescale 1ns/1ps
module bank_outstage #(
   parameter int W       = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_wire
      logic unused_clk;
      assign unused_clk = clk;
      assign q = rst_n ? d : '0;
   end
endmodule

// File: rtl/bank_mem_guard.sv
`timescale 1ns/1ps
module bank_mem_guard #(
   parameter int SEL_W   = 4,
   parameter bit OUT_REG = 1'b1,
   localparam int NUM_BANK = 1 << SEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SEL_W-1:0]    addr_hi,
   input  logic                mem_en,
   input  logic                dbin,
   input  logic                wr_cyc,
   input  logic [NUM_BANK-1:0] bank_on,
   input  logic [NUM_BANK-1:0] bank_wr_ok,
   input  logic                pwr_fail,
   output logic                ram_ce,
   output logic                ram_we,
   output logic                ram_oe,
   output logic                xcvr_en,
   output logic                xcvr_to_cpu,
   output logic [NUM_BANK-1:0] bank_act
);
   import bank_mem_pkg::*;
   localparam int PIPE_W = NUM_BANK + CTL_W;

   if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel
      $error("bank_mem_guard: SEL_W must be 1..8");
   end

   logic [NUM_BANK-1:0] onehot;
   bank_ctl_t           ctl_d;
   bank_ctl_t           ctl_q;
   logic [PIPE_W-1:0]   pipe_q;

   bank_decoder #(.SEL_W(SEL_W)) u_dec (
      .sel    (addr_hi),
      .strobe (mem_en),
      .onehot (onehot)
   );

   bank_gate #(.NUM_BANK(NUM_BANK)) u_gate (
      .onehot     (onehot),
      .bank_on    (bank_on),
      .bank_wr_ok (bank_wr_ok),
      .wr_cyc     (wr_cyc),
      .dbin       (dbin),
      .pwr_fail   (pwr_fail),
      .ctl        (ctl_d)
   );

   bank_outstage #(.W(PIPE_W), .OUT_REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({onehot, ctl_d}),
      .q     (pipe_q)
   );

   assign ctl_q       = pipe_q[CTL_W-1:0];
   assign bank_act    = pipe_q[PIPE_W-1:CTL_W];
   assign ram_ce      = ctl_q.ce;
   assign ram_we      = ctl_q.we;
   assign ram_oe      = ctl_q.oe;
   assign xcvr_en     = ctl_q.xen;
   assign xcvr_to_cpu = ctl_q.xdir;
endmodule

// File: rtl/bank_mem_guard_chk.sv
`timescale 1ns/1ps
module bank_mem_guard_chk #(
   parameter int SEL_W   = 4,
   parameter bit OUT_REG = 1'b1,
   localparam int NUM_BANK = 1 << SEL_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic [SEL_W-1:0]    addr_hi,
   input logic                mem_en,
   input logic                dbin,
   input logic                wr_cyc,
   input logic [NUM_BANK-1:0] bank_on,
   input logic [NUM_BANK-1:0] bank_wr_ok,
   input logic                pwr_fail,
   input logic                ram_ce,
   input logic                ram_we,
   input logic                ram_oe,
   input logic                xcvr_en,
   input logic                xcvr_to_cpu,
   input logic [NUM_BANK-1:0] bank_act
);
   logic [SEL_W-1:0]    s_addr;
   logic                s_mem, s_dbin, s_wr, s_pf;
   logic [NUM_BANK-1:0] s_on, s_ok;
   logic                armed;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed <= 1'b0;
            s_addr <= '0; s_mem <= 1'b0; s_dbin <= 1'b0; s_wr <= 1'b0;
            s_pf <= 1'b0; s_on <= '0; s_ok <= '0;
         end else begin
            armed <= 1'b1;
            s_addr <= addr_hi; s_mem <= mem_en; s_dbin <= dbin; s_wr <= wr_cyc;
            s_pf <= pwr_fail; s_on <= bank_on; s_ok <= bank_wr_ok;
         end
      end
   end else begin : g_comb
      assign armed = 1'b1;
      assign s_addr = addr_hi; assign s_mem = mem_en; assign s_dbin = dbin;
      assign s_wr = wr_cyc; assign s_pf = pwr_fail;
      assign s_on = bank_on; assign s_ok = bank_wr_ok;
   end

   always_comb begin
      AST_ACT_ONEHOT: assert ($onehot0(bank_act)); // R1
   end

   AST_ACT_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !s_mem |-> (bank_act == '0)); // R1
   AST_ACT_INDEX: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      s_mem |-> bank_act[s_addr]); // R1
   AST_CE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ram_ce |-> (s_mem && s_on[s_addr] && !s_pf)); // R2
   AST_WE_PERMIT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ram_we |-> (s_wr && !s_dbin && s_on[s_addr] && s_ok[s_addr])); // R3
   AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ram_we |-> ram_ce); // R3
   AST_XCVR_SELECT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      xcvr_en == (s_mem && s_on[s_addr])); // R4
   AST_XCVR_DIR: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      xcvr_to_cpu == s_dbin); // R5
   AST_OE_READ: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ram_oe == s_dbin); // R6
   AST_PWRFAIL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      s_pf |-> (!ram_ce && !ram_we)); // R7
   AST_OFF_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (s_mem && !s_on[s_addr]) |-> (!ram_ce && !ram_we && !xcvr_en)); // R8
endmodule

bind bank_mem_guard bank_mem_guard_chk #(.SEL_W(SEL_W), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .mem_en(mem_en), .dbin(dbin),
   .wr_cyc(wr_cyc), .bank_on(bank_on), .bank_wr_ok(bank_wr_ok), .pwr_fail(pwr_fail),
   .ram_ce(ram_ce), .ram_we(ram_we), .ram_oe(ram_oe), .xcvr_en(xcvr_en),
   .xcvr_to_cpu(xcvr_to_cpu), .bank_act(bank_act)
);

// File: tb/sim_bank_mem_guard.sv
`timescale 1ns/1ps
module sim_bank_mem_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr_hi = '0;
   logic        mem_en = 1'b0, dbin = 1'b0, wr_cyc = 1'b0, pwr_fail = 1'b0;
   logic [15:0] bank_on = '0, bank_wr_ok = '0;
   logic        ram_ce, ram_we, ram_oe, xcvr_en, xcvr_to_cpu;
   logic [15:0] bank_act;
   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   bank_mem_guard u0 (
      .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .mem_en(mem_en), .dbin(dbin),
      .wr_cyc(wr_cyc), .bank_on(bank_on), .bank_wr_ok(bank_wr_ok), .pwr_fail(pwr_fail),
      .ram_ce(ram_ce), .ram_we(ram_we), .ram_oe(ram_oe), .xcvr_en(xcvr_en),
      .xcvr_to_cpu(xcvr_to_cpu), .bank_act(bank_act)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge register it, compare at the next falling edge.
   task automatic cycle(input logic [3:0] a, input logic me, input logic rd, input logic wr,
                        input logic pf);
      logic sel, exp_we;
      addr_hi = a; mem_en = me; dbin = rd; wr_cyc = wr; pwr_fail = pf;
      @(posedge clk); @(negedge clk);
      sel    = me && bank_on[a];
      exp_we = sel && wr && !rd && bank_wr_ok[a] && !pf;
      chk("R1 bank_act", 32'(bank_act), me ? 32'(16'(1) << a) : 32'd0);
      chk("R2 ram_ce", 32'(ram_ce), 32'(sel && !pf));
      chk("R3 ram_we", 32'(ram_we), 32'(exp_we));
      chk("R4 xcvr_en", 32'(xcvr_en), 32'(sel));
      chk("R5 xcvr_to_cpu", 32'(xcvr_to_cpu), 32'(rd));
      chk("R6 ram_oe", 32'(ram_oe), 32'(rd));
   endtask

   task automatic t_reset;
      mem_en = 1'b1; dbin = 1'b1; bank_on = '1; bank_wr_ok = '1;
      @(negedge clk); @(negedge clk);
      chk("R9 reset outputs", {ram_ce, ram_we, ram_oe, xcvr_en, xcvr_to_cpu, bank_act}, '0);
      rst_n = 1'b1;
      mem_en = 1'b0; dbin = 1'b0;
   endtask

   task automatic t_latency;
      addr_hi = 4'd5; mem_en = 1'b1; dbin = 1'b1; wr_cyc = 1'b0; pwr_fail = 1'b0;
      bank_on = '1;
      #1;
      chk("R9 no change before edge", 32'(bank_act), 32'd0);
      @(posedge clk); @(negedge clk);
      chk("R9 after one edge", 32'(bank_act), 32'h0020);
      chk("R9 ce after one edge", 32'(ram_ce), 32'd1);
   endtask

   task automatic t_sweep_read_write;
      bank_on = '1; bank_wr_ok = '1;
      for (int b = 0; b < 16; b++) begin
         cycle(4'(b), 1'b1, 1'b1, 1'b0, 1'b0);   // R6 read
         cycle(4'(b), 1'b1, 1'b0, 1'b1, 1'b0);   // R3 write
      end
   endtask

   task automatic t_idle;
      bank_on = '1; bank_wr_ok = '1;
      for (int b = 0; b < 16; b += 5) cycle(4'(b), 1'b0, 1'b0, 1'b1, 1'b0); // R1 idle
   endtask

   task automatic t_protect_patterns;
      bank_on = '1;
      for (int p = 0; p < 4; p++) begin
         bank_wr_ok = (p == 0) ? 16'h5555 : (p == 1) ? 16'hAAAA :
                      (p == 2) ? 16'h0100 : 16'hFEFF;
         for (int b = 0; b < 16; b++) cycle(4'(b), 1'b1, 1'b0, 1'b1, 1'b0); // R3
      end
   endtask

   task automatic t_disabled_banks;
      bank_wr_ok = '1;
      for (int p = 0; p < 2; p++) begin
         bank_on = p[0] ? 16'h33CC : 16'hCC33;
         for (int b = 0; b < 16; b++) begin
            cycle(4'(b), 1'b1, 1'b0, 1'b1, 1'b0); // R8 write
            cycle(4'(b), 1'b1, 1'b1, 1'b0, 1'b0); // R8 read
         end
      end
   endtask

   task automatic t_power_fail;
      bank_on = '1; bank_wr_ok = '1;
      for (int b = 0; b < 16; b += 3) begin
         cycle(4'(b), 1'b1, 1'b0, 1'b1, 1'b1); // R7 write blocked
         cycle(4'(b), 1'b1, 1'b1, 1'b0, 1'b1); // R7 read blocked
         cycle(4'(b), 1'b1, 1'b0, 1'b1, 1'b0); // R7 recovery
      end
   endtask

   task automatic t_direction;
      bank_on = 16'h0000; bank_wr_ok = '0;
      cycle(4'd9, 1'b0, 1'b1, 1'b0, 1'b0); // R5 direction with no access
      cycle(4'd9, 1'b0, 1'b0, 1'b0, 1'b0); // R5
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_latency();
      t_sweep_read_write();
      t_idle();
      t_protect_patterns();
      t_disabled_banks();
      t_power_fail();
      t_direction();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule